// File: doc/BRIEF.md
# Pad Pull Configuration Sequencer

This block holds the pull-resistor setting of every pin on a 54-pin port and loads it through an indirect, timed protocol. Software first writes a 2-bit pull code into one shared code register. It then raises the strobe bits of the pins it wants to change, which sit in two strobe registers. Later it lowers those bits again. Each pin whose strobe bit falls copies the shared code into its own pull register, which drives the pad as a 2-bit setting.

Internal counters enforce the protocol. The code must be stable for at least `SETUP_CYCLES` cycles when a strobe bit rises. The strobe must then stay high for at least `HOLD_CYCLES` cycles before it falls. A fall that breaks either rule does not change the pin, and it sets a sticky timing error output. The per-pin pull state drives the pads only and cannot be read back over the register bus. The code register and both strobe registers return what was written to them.

Top module: `pull_seq_top`

## Requirements
- R1: After reset every pin's pull setting is 01 (pull-down). The code register reads 0, both strobe registers read 0, and `timingErr` is 0.
- R2: Byte address 0x94 reads back the last code written in bits 1:0, with all other bits 0. Address 0x98 reads back the strobe bits of pins 0 to 31. Address 0x9C reads back the strobe bits of pins 32 to 53 in bits 21:0, with bits 31:22 at 0. Any other address reads 0.
- R3: A valid fall loads the pin. A valid fall is a write that clears a strobe bit, where the bit rose at least `SETUP_CYCLES` cycles after the last code write and falls at least `HOLD_CYCLES` cycles after the most recent strobe rise on any pin. The pin's setting equals the code at the clock edge that takes the write. Code 00 means off, 01 pull-down and 10 pull-up.
- R4: Pins whose strobe bit does not fall keep their previous setting.
- R5: If a strobe bit rises fewer than `SETUP_CYCLES` cycles after the last code write, its later fall leaves the pin unchanged and sets `timingErr`.
- R6: If a strobe bit falls fewer than `HOLD_CYCLES` cycles after the most recent strobe rise, the pin is unchanged and `timingErr` is set.
- R7: A code write while a strobe bit is high cancels that pin's pending load. Its fall then leaves the pin unchanged and sets `timingErr`.
- R8: Code 11 is reserved. A valid fall under code 11 leaves the pin unchanged and does not set `timingErr`.
- R9: `timingErr` stays 1 once set, including across later valid loads, until reset.
- R10: Pull settings change only in the cycle a strobe register write clears a bit. Code writes and strobe rises alone never change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | 8 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from `regAddr` |
| pullState | output | 108 | Pull setting per pin, pin n in bits 2n+1:2n |
| timingErr | output | 1 | Sticky protocol timing error |

## Verification
The assertions check the following on every cycle:
- pull settings move only after a strobe register write;
- the timing error never clears, and it appears only after a strobe write;
- unused read-data bits stay 0;
- the reset state is correct.

Cycle counting relative to the setup and hold windows can only be shown by the bench scenarios. These include loads at exactly the minimum distance, loads one cycle short of it, cancellation by a mid-sequence code change, and the reserved code.

// File: rtl/pull_seq_pkg.sv
package pull_seq_pkg;

  localparam logic [7:0] ADDR_CODE   = 8'h94;
  localparam logic [7:0] ADDR_STB_LO = 8'h98;
  localparam logic [7:0] ADDR_STB_HI = 8'h9C;

  typedef enum logic [1:0] {
    PULL_OFF  = 2'b00,
    PULL_DOWN = 2'b01,
    PULL_UP   = 2'b10,
    PULL_RSVD = 2'b11
  } pull_code_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       codeWr;
    logic       loWr;
    logic       hiWr;
    logic       setupOk;
    logic       holdOk;
    logic [1:0] code;
  } seq_strobe_t;

endpackage

// File: rtl/pull_seq_ctrl.sv
module pull_seq_ctrl
  import pull_seq_pkg::*;
#(
  parameter int SETUP_CYCLES = 150,
  parameter int HOLD_CYCLES  = 150
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [7:0]  regAddr,
  input  logic [1:0]  codeIn,
  input  logic        riseAny,
  input  logic        badFall,
  output seq_strobe_t stb,
  output logic        timingErr
);
  localparam int SW = $clog2(SETUP_CYCLES + 1);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [SW-1:0] SETUP_MAX = SW'(SETUP_CYCLES);
  localparam logic [HW-1:0] HOLD_MAX  = HW'(HOLD_CYCLES);

  logic [1:0]    codeReg;
  logic [SW-1:0] setupCnt;
  logic [HW-1:0] holdCnt;
  logic          errReg;

  always_comb begin
    stb.codeWr  = regWe && (regAddr == ADDR_CODE);
    stb.loWr    = regWe && (regAddr == ADDR_STB_LO);
    stb.hiWr    = regWe && (regAddr == ADDR_STB_HI);
    stb.setupOk = (setupCnt == SETUP_MAX);
    stb.holdOk  = (holdCnt == HOLD_MAX);
    stb.code    = codeReg;
  end

  // counters hold the distance in edges since the last event, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeReg  <= PULL_OFF;
      setupCnt <= '0;
      holdCnt  <= '0;
      errReg   <= 1'b0;
    end else begin
      if (stb.codeWr) begin
        codeReg  <= codeIn;
        setupCnt <= SW'(1);
      end else if (setupCnt != SETUP_MAX) begin
        setupCnt <= setupCnt + SW'(1);
      end
      if (riseAny)
        holdCnt <= HW'(1);
      else if (holdCnt != HOLD_MAX)
        holdCnt <= holdCnt + HW'(1);
      if (badFall)
        errReg <= 1'b1;
    end
  end

  assign timingErr = errReg;
endmodule

// File: rtl/pull_seq_data.sv
module pull_seq_data
  import pull_seq_pkg::*;
#(
  parameter int NUM_PINS = 54
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seq_strobe_t           stb,
  input  logic [7:0]            regAddr,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  output logic [2*NUM_PINS-1:0] pullState,
  output logic                  riseAny,
  output logic                  badFall
);
  localparam int HI_W = NUM_PINS - 32;

  logic [NUM_PINS-1:0] stbBits, nextBits, armed, rising, falling, goodFall;

  always_comb begin
    nextBits = stbBits;
    if (stb.loWr) nextBits[31:0] = regWdata;
    if (stb.hiWr) nextBits[NUM_PINS-1:32] = regWdata[HI_W-1:0];
    rising   = nextBits & ~stbBits;
    falling  = stbBits & ~nextBits;
    goodFall = falling & armed & {NUM_PINS{stb.holdOk}};
  end

  assign riseAny = |rising;
  assign badFall = |(falling & ~goodFall);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stbBits <= '0;
      armed   <= '0;
    end else begin
      stbBits <= nextBits;
      if (stb.codeWr)
        armed <= '0;
      else
        armed <= (armed & ~rising) | (rising & {NUM_PINS{stb.setupOk}});
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [1:0] pullReg;
    always_ff @(posedge clk) begin
      if (!rstN)
        pullReg <= PULL_DOWN;
      else if (goodFall[p] && (stb.code != PULL_RSVD))
        pullReg <= stb.code;
    end
    assign pullState[2*p +: 2] = pullReg;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CODE:   regRdata = {30'b0, stb.code};
      ADDR_STB_LO: regRdata = stbBits[31:0];
      ADDR_STB_HI: regRdata = {{(32-HI_W){1'b0}}, stbBits[NUM_PINS-1:32]};
      default:     regRdata = '0;
    endcase
  end
endmodule

// File: rtl/pull_seq_top.sv
module pull_seq_top
  import pull_seq_pkg::*;
#(
  parameter int NUM_PINS     = 54,
  parameter int SETUP_CYCLES = 150,
  parameter int HOLD_CYCLES  = 150
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [7:0]            regAddr,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  output logic [2*NUM_PINS-1:0] pullState,
  output logic                  timingErr
);
  seq_strobe_t stb;
  logic        riseAny;
  logic        badFall;

  pull_seq_ctrl #(
    .SETUP_CYCLES(SETUP_CYCLES),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .codeIn   (regWdata[1:0]),
    .riseAny  (riseAny),
    .badFall  (badFall),
    .stb      (stb),
    .timingErr(timingErr)
  );

  pull_seq_data #(
    .NUM_PINS(NUM_PINS)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .pullState(pullState),
    .riseAny  (riseAny),
    .badFall  (badFall)
  );
endmodule

// File: rtl/pull_seq_checks.sv
module pull_seq_checks
  import pull_seq_pkg::*;
#(
  parameter int NUM_PINS = 54
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWe,
  input logic [7:0]            regAddr,
  input logic [31:0]           regRdata,
  input logic [2*NUM_PINS-1:0] pullState,
  input logic                  timingErr
);
  localparam int HI_W = NUM_PINS - 32;

  logic stbWrite;
  assign stbWrite = regWe && ((regAddr == ADDR_STB_LO) || (regAddr == ADDR_STB_HI));

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!timingErr && pullState == {NUM_PINS{PULL_DOWN}}));

  assert_code_read_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CODE) |-> (regRdata[31:2] == '0));

  assert_hi_read_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_STB_HI) |-> (regRdata[31:HI_W] == '0));

  assert_unmapped_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != ADDR_CODE && regAddr != ADDR_STB_LO && regAddr != ADDR_STB_HI)
      |-> (regRdata == '0));

  assert_pull_moves_on_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pullState) |-> $past(stbWrite));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    timingErr |=> timingErr);

  assert_err_from_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timingErr) |-> $past(stbWrite));
endmodule

bind pull_seq_top pull_seq_checks #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .regRdata (regRdata),
  .pullState(pullState),
  .timingErr(timingErr)
);

// File: tb/sim_pull_seq_top.sv
module sim_pull_seq_top;
  localparam int NP = 54;
  localparam int SU = 150;
  localparam int HD = 150;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            regWe = 1'b0;
  logic [7:0]      regAddr = 8'h00;
  logic [31:0]     regWdata = '0;
  logic [31:0]     regRdata;
  logic [2*NP-1:0] pullState;
  logic            timingErr;

  int checks = 0;
  int errors = 0;
  logic [1:0] model [NP];

  pull_seq_top #(.NUM_PINS(NP), .SETUP_CYCLES(SU), .HOLD_CYCLES(HD)) u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pullState(pullState),
    .timingErr(timingErr)
  );

  always #4 clk = ~clk;

  function automatic logic [2*NP-1:0] expVec();
    logic [2*NP-1:0] v;
    for (int i = 0; i < NP; i++) v[2*i +: 2] = model[i];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regAddr = 8'h00; regWdata = '0;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    chk(tag, {96'b0, regRdata}, {96'b0, exp});
    regAddr = 8'h00;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);
    for (int i = 0; i < NP; i++) model[i] = 2'b01;
  endtask

  task automatic checkPins(input string tag);
    chk(tag, {20'b0, pullState}, {20'b0, expVec()});
  endtask

  task automatic tReset();
    doReset();
    checkPins("R1 pull reset");
    chk("R1 err reset", {127'b0, timingErr}, 128'd0);
    rdChk("R1 code reset", 8'h94, 32'h0);
    rdChk("R1 lo reset", 8'h98, 32'h0);
    rdChk("R1 hi reset", 8'h9C, 32'h0);
  endtask

  task automatic tPullUp();
    wr(8'h94, 32'h2);
    checkPins("R10 after code write");
    idle(SU);
    wr(8'h98, 32'h8000_0021);
    wr(8'h9C, 32'h0020_0100);
    checkPins("R10 after rise");
    idle(HD);
    wr(8'h98, 32'h0);
    model[0] = 2'b10; model[5] = 2'b10; model[31] = 2'b10;
    checkPins("R3 R4 low bank load");
    wr(8'h9C, 32'h0);
    model[40] = 2'b10; model[53] = 2'b10;
    checkPins("R3 R4 high bank load");
    chk("R3 no error", {127'b0, timingErr}, 128'd0);
  endtask

  task automatic tBoundaryOff();
    wr(8'h94, 32'h0);
    idle(SU - 1);
    wr(8'h98, 32'h8);
    idle(HD - 1);
    wr(8'h98, 32'h0);
    model[3] = 2'b00;
    checkPins("R3 exact windows off code");
    chk("R3 exact windows no error", {127'b0, timingErr}, 128'd0);
  endtask

  task automatic tReserved();
    wr(8'h94, 32'h3);
    idle(SU);
    wr(8'h98, 32'h400);
    idle(HD);
    wr(8'h98, 32'h0);
    checkPins("R8 reserved no change");
    chk("R8 reserved no error", {127'b0, timingErr}, 128'd0);
  endtask

  task automatic tSetupShort();
    doReset();
    wr(8'h94, 32'h2);
    idle(SU - 2);
    wr(8'h98, 32'h80);
    idle(HD);
    wr(8'h98, 32'h0);
    checkPins("R5 short setup no change");
    chk("R5 short setup error", {127'b0, timingErr}, 128'd1);
    idle(SU);
    wr(8'h98, 32'h100);
    idle(HD);
    wr(8'h98, 32'h0);
    model[8] = 2'b10;
    checkPins("R9 later valid load");
    chk("R9 error stays", {127'b0, timingErr}, 128'd1);
    doReset();
    chk("R9 reset clears error", {127'b0, timingErr}, 128'd0);
  endtask

  task automatic tHoldShort();
    wr(8'h94, 32'h2);
    idle(SU);
    wr(8'h98, 32'h0010_0000);
    idle(HD - 2);
    wr(8'h98, 32'h0);
    checkPins("R6 short hold no change");
    chk("R6 short hold error", {127'b0, timingErr}, 128'd1);
    doReset();
  endtask

  task automatic tCancel();
    wr(8'h94, 32'h2);
    idle(SU);
    wr(8'h9C, 32'h2);
    idle(HD);
    wr(8'h94, 32'h0);
    checkPins("R10 code write while high");
    idle(SU);
    wr(8'h9C, 32'h0);
    checkPins("R7 cancelled no change");
    chk("R7 cancelled error", {127'b0, timingErr}, 128'd1);
  endtask

  task automatic tReadback();
    wr(8'h94, 32'hFFFF_FFFE);
    rdChk("R2 code readback", 8'h94, 32'h2);
    wr(8'h98, 32'hA5A5_A5A5);
    rdChk("R2 low bank readback", 8'h98, 32'hA5A5_A5A5);
    wr(8'h9C, 32'hFFFF_FFFF);
    rdChk("R2 high bank readback", 8'h9C, 32'h003F_FFFF);
    rdChk("R2 unmapped", 8'h00, 32'h0);
    checkPins("R10 readback writes");
  endtask

  initial begin
    idle(2);
    tReset();
    tPullUp();
    tBoundaryOff();
    tReserved();
    tSetupShort();
    tHoldShort();
    tCancel();
    tReadback();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule